// File: doc/BRIEF.md
# Signed-Amount Accumulator Shift Unit

This execution unit performs variable shifts on one of two 40-bit accumulators for a DSP with 16-bit instruction words. The shift count is a signed 16-bit operand. A positive count shifts left, a negative count shifts right by its magnitude, and zero leaves the value unchanged. There are four opcodes. Each one picks a logical or an arithmetic treatment of the accumulator. Each one also picks where the count comes from: the high word of an auxiliary register, or the middle word of the other accumulator.

Each cycle the unit decodes the presented instruction word against the current register values. For a matching opcode it registers the shifted result for the destination accumulator, together with zero and sign flags. A write-back strobe marks the result as valid. Other opcodes raise no strobe, and the registered result and flags hold. The low seven instruction bits belong to a parallel operation in another unit and are ignored here.

Top module: `acc_shift_unit`

## Requirements
- R1: Instruction bit 7 must be 1 for any match. Four patterns are recognised in bits 15..9: `001101x` is logical with an auxiliary count, `001110x` is arithmetic with an auxiliary count, `0011110` is logical with an accumulator count, and `0011111` is arithmetic with an accumulator count. Bits 6..0 have no effect.
- R2: A positive count n shifts the 40-bit operand left by n, filling with zeros. Bits moved above bit 39 are lost.
- R3: A negative count shifts right by its magnitude. Logical opcodes fill from the top with zeros.
- R4: Arithmetic opcodes fill a right shift with copies of operand bit 39.
- R5: A count of zero writes back the operand unchanged.
- R6: A magnitude of 40 or more yields all zeros. The one exception is an arithmetic right shift of an operand whose bit 39 is 1, which yields all ones.
- R7: For the auxiliary-count opcodes, the count is `axh1_i` when bit 9 is 1 and `axh0_i` otherwise. For the accumulator-count opcodes, the count is bits 31..16 of the accumulator that is not the destination.
- R8: Bit 8 selects the destination and operand accumulator (0 selects acc0, 1 selects acc1). The result, `wb_dst_o` and `wb_valid_o`=1 appear after the next rising clock edge.
- R9: `flag_zero_o` is 1 exactly when the registered result is 0, and `flag_sign_o` equals result bit 39. Both update on the same edge as the result.
- R10: For a non-matching opcode, `wb_valid_o` is 0 after the edge, and `wb_acc_o`, `wb_dst_o` and both flags keep their previous values.
- R11: An active-low asynchronous reset clears `wb_valid_o`, `wb_dst_o`, `wb_acc_o` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| acc0_i | input | 40 | Accumulator 0 value |
| acc1_i | input | 40 | Accumulator 1 value |
| axh0_i | input | 16 | Auxiliary register 0 high word |
| axh1_i | input | 16 | Auxiliary register 1 high word |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_dst_o | output | 1 | Destination accumulator index |
| wb_acc_o | output | 40 | Shifted result |
| flag_zero_o | output | 1 | Result is zero |
| flag_sign_o | output | 1 | Result bit 39 |

## Verification
The assertions check the following on every cycle:
- at most one opcode pattern matches;
- a non-matching opcode leaves the outputs frozen;
- a zero count passes the operand through;
- an out-of-range magnitude gives zero unless it is a sign-filled arithmetic right shift;
- the sign flag tracks bit 39 of the result.

Other behaviour can only be shown by the bench's scenarios. This covers the exact bit patterns of left, logical-right and arithmetic-right shifts, and the selection of the count source and the destination. It also covers the boundary counts 39, 40, -39, -40 and -32768, and the asynchronous reset clearing outputs in the middle of a run.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  typedef enum logic {
    SHK_LOGIC = 1'b0,
    SHK_ARITH = 1'b1
  } shift_kind_e;

  typedef enum logic {
    AMT_AUX = 1'b0,
    AMT_ACC = 1'b1
  } amt_src_e;

  typedef struct packed {
    logic        valid;
    shift_kind_e kind;
    amt_src_e    src;
    logic        dst;
    logic        aux_sel;
  } shift_op_t;

endpackage

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
  import acc_shift_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output shift_op_t          op_o
);

  localparam int TOP = INSTR_W - 1;

  logic [3:0] hit;
  logic       unused_ext;

  // ext slot bits belong to another unit
  assign unused_ext = ^instr_i[6:0];

  always_comb begin
    hit[0] = (instr_i[TOP -: 6] == 6'b001101) && instr_i[7];
    hit[1] = (instr_i[TOP -: 6] == 6'b001110) && instr_i[7];
    hit[2] = (instr_i[TOP -: 7] == 7'b0011110) && instr_i[7];
    hit[3] = (instr_i[TOP -: 7] == 7'b0011111) && instr_i[7];

    op_o.valid   = |hit;
    op_o.kind    = (hit[1] | hit[3]) ? SHK_ARITH : SHK_LOGIC;
    op_o.src     = (hit[2] | hit[3]) ? AMT_ACC : AMT_AUX;
    op_o.dst     = instr_i[8];
    op_o.aux_sel = instr_i[9];
  end

  assert_onehot_decode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core #(
  parameter int ACC_W = 40,
  parameter int AMT_W = 16
) (
  input  logic [ACC_W-1:0] val_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             arith_i,
  output logic [ACC_W-1:0] res_o
);

  localparam int MAG_W = AMT_W + 1;
  localparam int STG   = $clog2(ACC_W);

  logic             neg;
  logic             fill;
  logic             sat;
  logic [MAG_W-1:0] amt_ext;
  logic [MAG_W-1:0] mag;
  logic [ACC_W-1:0] stg [STG+1];

  assign neg     = amt_i[AMT_W-1];
  assign fill    = arith_i & val_i[ACC_W-1];
  assign amt_ext = {amt_i[AMT_W-1], amt_i};
  assign mag     = neg ? (~amt_ext + 1'b1) : amt_ext;
  assign sat     = (mag >= MAG_W'(ACC_W));
  assign stg[0]  = val_i;

  // log shifter: stage k moves by 2**k, direction from sign
  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int S = 1 << k;
    always_comb begin
      if (!mag[k])
        stg[k+1] = stg[k];
      else if (neg)
        stg[k+1] = {{S{fill}}, stg[k][ACC_W-1:S]};
      else
        stg[k+1] = {stg[k][ACC_W-1-S:0], {S{1'b0}}};
    end
  end

  assign res_o = sat ? (neg ? {ACC_W{fill}} : '0) : stg[STG];

endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int WORD_W  = 16,
  parameter int MID_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [ACC_W-1:0]  acc0_i,
  input  logic [ACC_W-1:0]  acc1_i,
  input  logic [WORD_W-1:0] axh0_i,
  input  logic [WORD_W-1:0] axh1_i,
  output logic              wb_valid_o,
  output logic              wb_dst_o,
  output logic [ACC_W-1:0]  wb_acc_o,
  output logic              flag_zero_o,
  output logic              flag_sign_o
);

  shift_op_t         op;
  logic [ACC_W-1:0]  operand;
  logic [WORD_W-1:0] amt;
  logic [ACC_W-1:0]  res;

  acc_shift_decode #(.INSTR_W(WORD_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .instr_i(instr_i),
    .op_o   (op)
  );

  assign operand = op.dst ? acc1_i : acc0_i;

  always_comb begin
    if (op.src == AMT_ACC)
      amt = op.dst ? acc0_i[MID_LSB +: WORD_W] : acc1_i[MID_LSB +: WORD_W];
    else
      amt = op.aux_sel ? axh1_i : axh0_i;
  end

  acc_shift_core #(.ACC_W(ACC_W), .AMT_W(WORD_W)) u_core (
    .val_i  (operand),
    .amt_i  (amt),
    .arith_i(op.kind == SHK_ARITH),
    .res_o  (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o  <= 1'b0;
      wb_dst_o    <= 1'b0;
      wb_acc_o    <= '0;
      flag_zero_o <= 1'b0;
      flag_sign_o <= 1'b0;
    end else begin
      wb_valid_o <= op.valid;
      if (op.valid) begin
        wb_dst_o    <= op.dst;
        wb_acc_o    <= res;
        flag_zero_o <= (res == '0);
        flag_sign_o <= res[ACC_W-1];
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op.valid |=> !wb_valid_o && $stable(wb_acc_o) && $stable(wb_dst_o)
                  && $stable(flag_zero_o) && $stable(flag_sign_o));

  assert_zero_amt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.valid && amt == '0) |=> wb_acc_o == $past(operand));

  assert_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op.valid && ($signed(amt) >= ACC_W || $signed(amt) <= -ACC_W)
     && !(op.kind == SHK_ARITH && amt[WORD_W-1] && operand[ACC_W-1]))
    |=> wb_acc_o == '0);

  assert_sign_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (flag_sign_o == wb_acc_o[ACC_W-1]) && (flag_zero_o == (wb_acc_o == '0)));

endmodule

// File: tb/acc_shift_unit_tb_top.sv
module acc_shift_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [15:0] instr;
    logic [39:0] a0;
    logic [39:0] a1;
    logic [15:0] x0;
    logic [15:0] x1;
    logic        v;
    logic        d;
    logic [39:0] r;
    logic        z;
    logic        s;
    logic [7:0]  req;
  } vec_t;

  // instr, acc0, acc1, axh0, axh1, valid, dst, result, zero, sign, req
  localparam vec_t VECS [NVEC] = '{
    '{16'h3480, 40'h00_0000_1234, 40'h0, 16'h0004, 16'h0, 1'b1, 1'b0, 40'h00_0001_2340, 1'b0, 1'b0, 8'd2},  // R2 left 4
    '{16'h3480, 40'h80_0000_0000, 40'h0, 16'hFFFC, 16'h0, 1'b1, 1'b0, 40'h08_0000_0000, 1'b0, 1'b0, 8'd3},  // R3 logical right
    '{16'h3880, 40'h80_0000_0000, 40'h0, 16'hFFFC, 16'h0, 1'b1, 1'b0, 40'hF8_0000_0000, 1'b0, 1'b1, 8'd4},  // R4 arith right
    '{16'h3B80, 40'h0, 40'h40_0000_0001, 16'h0, 16'h0001, 1'b1, 1'b1, 40'h80_0000_0002, 1'b0, 1'b1, 8'd7},  // R7 aux1 -> acc1
    '{16'h3C80, 40'hFF_0000_0100, 40'h00_FFF8_0000, 16'h0, 16'h0, 1'b1, 1'b0, 40'h00_FF00_0001, 1'b0, 1'b0, 8'd7}, // R7 acc1 mid
    '{16'h3F80, 40'h00_0010_0000, 40'h00_0000_ABCD, 16'h0, 16'h0, 1'b1, 1'b1, 40'h00_ABCD_0000, 1'b0, 1'b0, 8'd8}, // R8 dst acc1
    '{16'h3E80, 40'hC0_0000_0000, 40'h00_FFF0_0000, 16'h0, 16'h0, 1'b1, 1'b0, 40'hFF_FFC0_0000, 1'b0, 1'b1, 8'd4}, // R4 arith via acc
    '{16'h3780, 40'h0, 40'h12_3456_789A, 16'h0, 16'h0000, 1'b1, 1'b1, 40'h12_3456_789A, 1'b0, 1'b0, 8'd5},  // R5 zero count
    '{16'h3480, 40'hFF_FFFF_FFFF, 40'h0, 16'h0028, 16'h0, 1'b1, 1'b0, 40'h00_0000_0000, 1'b1, 1'b0, 8'd6},  // R6 left 40
    '{16'h3880, 40'h80_0000_0000, 40'h0, 16'hFFD8, 16'h0, 1'b1, 1'b0, 40'hFF_FFFF_FFFF, 1'b0, 1'b1, 8'd6},  // R6 arith -40 neg
    '{16'h3880, 40'h7F_FFFF_FFFF, 40'h0, 16'h8000, 16'h0, 1'b1, 1'b0, 40'h00_0000_0000, 1'b1, 1'b0, 8'd6},  // R6 -32768 pos
    '{16'h3480, 40'h00_0000_0003, 40'h0, 16'h0027, 16'h0, 1'b1, 1'b0, 40'h80_0000_0000, 1'b0, 1'b1, 8'd2},  // R2 left 39
    '{16'h3480, 40'h80_0000_0000, 40'h0, 16'hFFD9, 16'h0, 1'b1, 1'b0, 40'h00_0000_0001, 1'b0, 1'b0, 8'd3},  // R3 right 39
    '{16'h35FF, 40'h0, 40'h00_0000_0001, 16'h0003, 16'h0, 1'b1, 1'b1, 40'h00_0000_0008, 1'b0, 1'b0, 8'd1},  // R1 ext bits ignored
    '{16'h3400, 40'h55_5555_5555, 40'h1, 16'h0001, 16'h1, 1'b0, 1'b1, 40'h00_0000_0008, 1'b0, 1'b0, 8'd10} // R10 bit7 clear: hold
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic [39:0] acc0_i = '0;
  logic [39:0] acc1_i = '0;
  logic [15:0] axh0_i = '0;
  logic [15:0] axh1_i = '0;
  logic        wb_valid_o, wb_dst_o, flag_zero_o, flag_sign_o;
  logic [39:0] wb_acc_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_shift_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i),
    .acc0_i(acc0_i), .acc1_i(acc1_i), .axh0_i(axh0_i), .axh1_i(axh1_i),
    .wb_valid_o(wb_valid_o), .wb_dst_o(wb_dst_o), .wb_acc_o(wb_acc_o),
    .flag_zero_o(flag_zero_o), .flag_sign_o(flag_sign_o)
  );

  task automatic check(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    instr_i = v.instr; acc0_i = v.a0; acc1_i = v.a1; axh0_i = v.x0; axh1_i = v.x1;
  endtask

  task automatic check_outputs(input vec_t v);
    check("valid", int'(v.req), 64'(wb_valid_o), 64'(v.v));
    check("dst",   int'(v.req), 64'(wb_dst_o),   64'(v.d));
    check("acc",   int'(v.req), 64'(wb_acc_o),   64'(v.r));
    check("zero",  int'(v.req), 64'(flag_zero_o), 64'(v.z));
    check("sign",  int'(v.req), 64'(flag_sign_o), 64'(v.s));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 outputs clear while in reset
    check("reset valid", 11, 64'(wb_valid_o), 64'd0);
    check("reset acc",   11, 64'(wb_acc_o),   64'd0);
    check("reset flags", 11, 64'({flag_zero_o, flag_sign_o, wb_dst_o}), 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk_i);
      check_outputs(VECS[i]);
    end

    // R10 second non-matching pattern (unused group) keeps held state
    drive('{16'h3080, 40'h1, 40'h1, 16'h1, 16'h1, 1'b0, 1'b1, 40'h8, 1'b0, 1'b0, 8'd10});
    @(negedge clk_i);
    check("r10_hold acc", 10, 64'(wb_acc_o), 64'h8);
    check("r10_hold valid", 10, 64'(wb_valid_o), 64'd0);

    // R8 result appears only after the edge
    drive('{16'h3480, 40'h00_0000_0001, 40'h0, 16'h0001, 16'h0, 1'b1, 1'b0, 40'h2, 1'b0, 1'b0, 8'd8});
    #1;
    check("r8_before_edge", 8, 64'(wb_acc_o), 64'h8);
    @(negedge clk_i);
    check("r8_after_edge", 8, 64'(wb_acc_o), 64'h2);

    // R11 asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    check("r11_async acc", 11, 64'(wb_acc_o), 64'd0);
    check("r11_async valid", 11, 64'(wb_valid_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule